// File: doc/BRIEF.md
# Dual-Address DMA Channel

This block is one DMA channel that moves a block of data in two phases: it reads from a source address, then writes to a destination address. Each side has its own access size (byte, 16-bit word, 32-bit longword or 16-byte line) and its own addressing, either fixed or incrementing. When the two sizes differ, an internal 32-bit holding register packs or unpacks the data. The channel places every access on the correct byte lanes of a 32-bit request/acknowledge memory bus with byte enables.

Software programs the source address, destination address and a byte count. It then writes the control word with the enable bit set. At the start of each chunk the channel waits for its request input. The count falls as data is written. When the count reaches zero, the channel sets done and can raise an interrupt. A start with bad settings sets an error flag and issues no bus cycles. Clearing enable, or writing the reset bit, stops a transfer that is running.

Top module: `dualaddr_dma_chan`

## Requirements
- R1: Each chunk is made of source reads followed by destination writes, and the two never mix. A chunk is the larger of the two beat sizes. Reads fill the holding register first, and then writes drain it. Read bytes fill the holding register from byte 0 upward, and writes take bytes out in the same order.
- R2: The size code sets the bytes per beat: 0 is a longword (4 bytes), 1 is a byte (1), 2 is a word (2), and 3 is a line, carried as longword beats of 4 bytes. Full sizes for alignment are 4, 1, 2 and 16 bytes.
- R3: When a side's fixed bit is 1, that side's address never changes. When it is 0, the address advances by the beat size after each accepted access.
- R4: Lanes are little-endian. A byte access at address a uses mem_be = 1<<a[1:0]. A word access uses 0011 or 1100, chosen by a[1]. A longword access uses 1111. Write data carries each byte on the lane of its own address.
- R5: The count register holds bytes and has 24 significant bits; bits 31:24 read as zero. Each accepted write subtracts the destination beat size from the count.
- R6: When the last write is accepted, the count reads 0, the done status bit is set, and the channel stops issuing bus cycles.
- R7: A start sets the error status bit and issues no bus cycle in any of these cases: the count is 0, the count is not a multiple of the larger full size, or either address is not aligned to its side's full size.
- R8: A control write with enable 0 or with reset set stops a running transfer, and no further bus cycles follow. Reset also clears the done and error status bits.
- R9: irq equals done AND the interrupt-enable bit. Done and error are write-one-to-clear at status bits 0 and 1, so clearing done drops irq.
- R10: A chunk starts only while xfer_req is high. While it is low, a busy channel issues no bus cycles.
- R11: The register map uses word indexes on reg_addr. Index 0 is control: bit 0 enable (reads back as busy), bit 1 interrupt enable, bit 2 reset, bits 5:4 source size, bit 6 source fixed, bits 9:8 destination size, bit 10 destination fixed. Index 1 is the source address, 2 the destination address, 3 the count, and 4 the status register (bit 0 done, bit 1 error, bit 2 busy).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| xfer_req | input | 1 | Request that allows the next chunk to start |
| mem_req | output | 1 | Bus access request |
| mem_we | output | 1 | Bus write (1) or read (0) |
| mem_addr | output | AW | Bus byte address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| irq | output | 1 | Completion interrupt |

## Verification
The bench targets mixed-size pairs, because they exercise packing. It runs byte reads into longword writes, longword reads into byte writes to a fixed address, and word reads into a fixed line destination. A design that misplaces holding-register bytes would write data in the wrong order, and one with a wrong lane mapping would drive the wrong byte enables. Line beats and fixed sides are included, and a design that advanced a fixed address would show up as an unexpected address at the scoreboard. A group of bad starts (zero count, a count that is not a multiple, a misaligned address) must produce no bus traffic at all. Abort and request gating are checked by holding xfer_req low and then disabling the channel, since a design that ignored either one would issue cycles the scoreboard never expected.

// File: rtl/dualaddr_dma_chan.sv
module dualaddr_dma_chan #(
  parameter int AW   = 32,
  parameter int CNTW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          xfer_req,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          irq
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RD, S_WR} st_t;

  function automatic logic [2:0] beat_of(input logic [1:0] s);
    case (s)
      2'd1:    beat_of = 3'd1;
      2'd2:    beat_of = 3'd2;
      default: beat_of = 3'd4;
    endcase
  endfunction

  function automatic logic [4:0] full_of(input logic [1:0] s);
    case (s)
      2'd0:    full_of = 5'd4;
      2'd1:    full_of = 5'd1;
      2'd2:    full_of = 5'd2;
      default: full_of = 5'd16;
    endcase
  endfunction

  function automatic logic [3:0] be_of(input logic [2:0] b, input logic [1:0] a);
    case (b)
      3'd1:    be_of = 4'b0001 << a;
      3'd2:    be_of = a[1] ? 4'b1100 : 4'b0011;
      default: be_of = 4'b1111;
    endcase
  endfunction

  st_t            state;
  logic           ie, sfix, dfix, done, err;
  logic [1:0]     ssz, dsz;
  logic [AW-1:0]  src, dst;
  logic [CNTW-1:0] cnt;
  logic [31:0]    hold;
  logic [2:0]     ptr;

  logic busy, ctrl_wr, start, abort, cfg_bad;
  logic [2:0] sb, db, chunk, ptr_s, ptr_d;
  logic [4:0] fs_n, fd_n, big_m1, fs_m1, fd_m1;
  logic [4:0] sh_r, sh_w;
  logic [31:0] rlane, rmask, wsrc;

  assign busy    = (state != S_IDLE);
  assign ctrl_wr = reg_wr && (reg_addr == 3'd0);
  assign start   = ctrl_wr && reg_wdata[0] && !reg_wdata[2] && !busy;
  assign abort   = ctrl_wr && (!reg_wdata[0] || reg_wdata[2]) && busy;

  assign sb    = beat_of(ssz);
  assign db    = beat_of(dsz);
  assign chunk = (sb > db) ? sb : db;
  assign ptr_s = ptr + sb;
  assign ptr_d = ptr + db;

  assign fs_n   = full_of(reg_wdata[5:4]);
  assign fd_n   = full_of(reg_wdata[9:8]);
  assign fs_m1  = fs_n - 5'd1;
  assign fd_m1  = fd_n - 5'd1;
  assign big_m1 = ((fs_n > fd_n) ? fs_n : fd_n) - 5'd1;
  assign cfg_bad = (cnt == '0) || |(cnt[3:0] & big_m1[3:0]) ||
                   |(src[3:0] & fs_m1[3:0]) || |(dst[3:0] & fd_m1[3:0]);

  assign sh_r  = {ptr[1:0], 3'b000};
  assign sh_w  = {ptr[1:0], 3'b000};
  assign rlane = mem_rdata >> {src[1:0], 3'b000};
  assign rmask = (sb == 3'd1) ? 32'h0000_00FF : (sb == 3'd2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign wsrc  = hold >> sh_w;

  assign mem_req   = (state == S_RD) || (state == S_WR);
  assign mem_we    = (state == S_WR);
  assign mem_addr  = (state == S_WR) ? dst : src;
  assign mem_be    = (state == S_WR) ? be_of(db, dst[1:0]) : be_of(sb, src[1:0]);
  assign mem_wdata = (db == 3'd1) ? {4{wsrc[7:0]}} :
                     (db == 3'd2) ? {2{wsrc[15:0]}} : wsrc;
  assign irq = done && ie;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {21'd0, dfix, dsz, 1'b0, sfix, ssz, 2'b00, ie, busy};
      3'd1:    reg_rdata = 32'(src);
      3'd2:    reg_rdata = 32'(dst);
      3'd3:    reg_rdata = 32'(cnt);
      3'd4:    reg_rdata = {29'd0, busy, err, done};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ie <= 1'b0; sfix <= 1'b0; dfix <= 1'b0; ssz <= 2'd0; dsz <= 2'd0;
      src <= '0; dst <= '0; cnt <= '0; hold <= '0; ptr <= '0;
      done <= 1'b0; err <= 1'b0;
    end else begin
      if (reg_wr && !busy) begin
        case (reg_addr)
          3'd0: begin
            ie   <= reg_wdata[1];
            ssz  <= reg_wdata[5:4];
            sfix <= reg_wdata[6];
            dsz  <= reg_wdata[9:8];
            dfix <= reg_wdata[10];
          end
          3'd1: src <= reg_wdata[AW-1:0];
          3'd2: dst <= reg_wdata[AW-1:0];
          3'd3: cnt <= reg_wdata[CNTW-1:0];
          default: ;
        endcase
      end
      if (reg_wr && reg_addr == 3'd4) begin
        if (reg_wdata[0]) done <= 1'b0;
        if (reg_wdata[1]) err  <= 1'b0;
      end
      if (ctrl_wr && reg_wdata[2]) begin
        done <= 1'b0;
        err  <= 1'b0;
      end

      if (abort) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: if (start) begin
            done <= 1'b0;
            ptr  <= '0;
            if (cfg_bad) err <= 1'b1;
            else begin
              err   <= 1'b0;
              state <= S_WAIT;
            end
          end
          S_WAIT: if (xfer_req) state <= S_RD;
          S_RD: if (mem_ack) begin
            hold <= (hold & ~(rmask << sh_r)) | ((rlane & rmask) << sh_r);
            if (!sfix) src <= src + AW'(sb);
            if (ptr_s == chunk) begin
              ptr   <= '0;
              state <= S_WR;
            end else ptr <= ptr_s;
          end
          S_WR: if (mem_ack) begin
            if (!dfix) dst <= dst + AW'(db);
            cnt <= cnt - CNTW'(db);
            if (ptr_d == chunk) begin
              ptr <= '0;
              if (cnt == CNTW'(db)) begin
                done  <= 1'b1;
                state <= S_IDLE;
              end else state <= S_WAIT;
            end else ptr <= ptr_d;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/dualaddr_dma_chan_chk.sv
module dualaddr_dma_chan_chk #(
  parameter int AW   = 32,
  parameter int CNTW = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_ack,
  input logic [AW-1:0]   mem_addr,
  input logic [3:0]      mem_be,
  input logic            irq,
  input logic            done_q,
  input logic [CNTW-1:0] cnt_q,
  input logic            busy,
  input logic            ctrl_wr
);

  a_r4_byte_lane: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && $countones(mem_be) == 1 |-> mem_be == (4'b0001 << mem_addr[1:0]));

  a_r4_word_lane: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && $countones(mem_be) == 2 |->
      (mem_be == 4'b0011 && mem_addr[1:0] == 2'd0) || (mem_be == 4'b1100 && mem_addr[1:0] == 2'd2));

  a_r4_long_lane: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_be == 4'b1111 |-> mem_addr[1:0] == 2'd0);

  a_r9_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_q);

  a_r6_done_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> cnt_q == '0);

  a_r5_count_falls: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> cnt_q <= $past(cnt_q));

  a_r1_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !ctrl_wr |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

endmodule

bind dualaddr_dma_chan dualaddr_dma_chan_chk #(.AW(AW), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_be(mem_be), .irq(irq), .done_q(done), .cnt_q(cnt),
  .busy(busy), .ctrl_wr(ctrl_wr)
);

// File: tb/dualaddr_dma_chan_tb.sv
module dualaddr_dma_chan_tb;

  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] data;
  } op_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        xfer_req = 1'b0;
  logic        mem_req, mem_we, mem_ack, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        ack_en = 1'b0;
  logic [31:0] mem [256];

  int total = 0;
  int bad = 0;
  int cyc = 0;
  op_t exp_q[$];

  always #2 clk = ~clk;

  assign mem_ack   = mem_req && ack_en;
  assign mem_rdata = mem[mem_addr[9:2]];

  dualaddr_dma_chan u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .xfer_req(xfer_req), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    lane_mask = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      ack_en = (cyc % 3) != 1;
      if (mem_req && ack_en) begin
        if (exp_q.size() == 0) begin
          check(0, "R7/R8/R10 unexpected bus op", mem_addr, 32'hFFFF_FFFF);
        end else begin
          op_t e;
          e = exp_q.pop_front();
          check(mem_we == e.we, "R1 op order we", {31'd0, mem_we}, {31'd0, e.we});
          check(mem_addr == e.addr, "R3 address", mem_addr, e.addr);
          check(mem_be == e.be, "R4 byte enables", {28'd0, mem_be}, {28'd0, e.be});
          if (e.we)
            check((mem_wdata & lane_mask(e.be)) == (e.data & lane_mask(e.be)),
                  "R1/R4 write data", mem_wdata & lane_mask(e.be), e.data & lane_mask(e.be));
        end
        if (mem_we) begin
          for (int k = 0; k < 4; k++)
            if (mem_be[k]) mem[mem_addr[9:2]][8*k +: 8] = mem_wdata[8*k +: 8];
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  function automatic int beat(input int s);
    beat = (s == 1) ? 1 : (s == 2) ? 2 : 4;
  endfunction

  function automatic logic [3:0] be_for(input int b, input logic [31:0] a);
    if (b == 1) be_for = 4'b0001 << a[1:0];
    else if (b == 2) be_for = a[1] ? 4'b1100 : 4'b0011;
    else be_for = 4'b1111;
  endfunction

  function automatic logic [31:0] ctrlw(input bit ie, input int ss, input bit sf, input int ds, input bit df);
    ctrlw = 32'd1 | (32'(ie) << 1) | (32'(ss) << 4) | (32'(sf) << 6) | (32'(ds) << 8) | (32'(df) << 10);
  endfunction

  task automatic gen(input int ss, input bit sf, input int ds, input bit df,
                     input logic [31:0] s0, input logic [31:0] d0, input int n);
    logic [7:0] bytes[$];
    logic [31:0] s, d;
    int sb, db, chunk, rem;
    s = s0; d = d0; rem = n;
    sb = beat(ss); db = beat(ds); chunk = (sb > db) ? sb : db;
    while (rem > 0) begin
      for (int f = 0; f < chunk; f += sb) begin
        op_t o;
        o.we = 1'b0; o.addr = s; o.be = be_for(sb, s); o.data = 32'd0;
        exp_q.push_back(o);
        for (int k = 0; k < sb; k++) begin
          logic [31:0] a;
          a = s + 32'(k);
          bytes.push_back(mem[a[9:2]][8*a[1:0] +: 8]);
        end
        if (!sf) s = s + 32'(sb);
      end
      for (int f = 0; f < chunk; f += db) begin
        op_t o;
        o.we = 1'b1; o.addr = d; o.be = be_for(db, d); o.data = 32'd0;
        for (int k = 0; k < db; k++) begin
          logic [31:0] a;
          a = d + 32'(k);
          o.data[8*a[1:0] +: 8] = bytes.pop_front();
        end
        exp_q.push_back(o);
        if (!df) d = d + 32'(db);
        rem -= db;
      end
    end
  endtask

  task automatic wait_end(output logic [31:0] st);
    st = 32'd0;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd4, st);
      if (st[0] || st[1]) break;
    end
  endtask

  task automatic run_ok(input string tag, input bit ie, input int ss, input bit sf, input int ds,
                        input bit df, input logic [31:0] s, input logic [31:0] d, input int n);
    logic [31:0] v;
    gen(ss, sf, ds, df, s, d, n);
    wr(3'd1, s); wr(3'd2, d); wr(3'd3, 32'(n));
    xfer_req = 1'b1;
    wr(3'd0, ctrlw(ie, ss, sf, ds, df));
    wait_end(v);
    check(v[2:0] == 3'b001, {tag, " R6 status done"}, v, 32'd1);
    check(exp_q.size() == 0, {tag, " R1 all ops seen"}, 32'(exp_q.size()), 32'd0);
    rd(3'd3, v);
    check(v == 32'd0, {tag, " R6 count zero"}, v, 32'd0);
    #1 check(irq == ie, {tag, " R9 irq"}, {31'd0, irq}, {31'd0, ie});
    wr(3'd4, 32'd1);
    rd(3'd4, v);
    #1 check(v[0] == 1'b0 && irq == 1'b0, {tag, " R9 done cleared"}, {v[31:1], irq}, 32'd0);
    exp_q.delete();
  endtask

  task automatic run_bad(input string tag, input int ss, input int ds,
                         input logic [31:0] s, input logic [31:0] d, input int n);
    logic [31:0] v;
    wr(3'd1, s); wr(3'd2, d); wr(3'd3, 32'(n));
    xfer_req = 1'b1;
    wr(3'd0, ctrlw(1, ss, 0, ds, 0));
    repeat (10) @(negedge clk);
    rd(3'd4, v);
    check(v[2:0] == 3'b010, {tag, " R7 error flagged"}, v, 32'd2);
    wr(3'd4, 32'd2);
    rd(3'd4, v);
    check(v[1] == 1'b0, {tag, " R9 error w1c"}, v, 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 256; i++)
      mem[i] = {8'(i) ^ 8'h5A, 8'(i * 7), 8'(i + 49), ~8'(i)};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(3'd4, v);
    check(v == 32'd0, "R11 reset status", v, 32'd0);
    rd(3'd0, v);
    check(v == 32'd0, "R11 reset control", v, 32'd0);
    #1 check(mem_req == 1'b0 && irq == 1'b0, "R9 reset outputs", {30'd0, mem_req, irq}, 32'd0);

    wr(3'd3, 32'hFF00_0010);
    rd(3'd3, v);
    check(v == 32'h0000_0010, "R5 count 24 bits", v, 32'h10);

    run_ok("long-long", 1, 0, 0, 0, 0, 32'h010, 32'h200, 16);
    run_ok("byte-long", 1, 1, 0, 0, 0, 32'h021, 32'h240, 8);
    run_ok("long-bytefix", 1, 0, 0, 1, 1, 32'h030, 32'h283, 8);
    run_ok("wordfix-word", 1, 2, 1, 2, 0, 32'h042, 32'h2A2, 6);
    run_ok("line-long R2", 1, 3, 0, 0, 0, 32'h060, 32'h2C0, 32);
    run_ok("word-linefix R3", 1, 2, 0, 3, 1, 32'h080, 32'h300, 16);
    run_ok("noie R9", 0, 0, 0, 2, 0, 32'h0A0, 32'h320, 8);

    run_bad("cnt-multiple", 0, 0, 32'h010, 32'h200, 6);
    run_bad("src-misalign", 2, 2, 32'h041, 32'h200, 4);
    run_bad("line-misalign", 0, 3, 32'h010, 32'h308, 16);
    run_bad("cnt-zero", 1, 1, 32'h010, 32'h200, 0);

    // R10 gating then R8 abort
    xfer_req = 1'b0;
    wr(3'd1, 32'h100); wr(3'd2, 32'h380); wr(3'd3, 32'd64);
    wr(3'd0, ctrlw(1, 0, 0, 0, 0));
    repeat (12) @(negedge clk);
    rd(3'd4, v);
    check(v[2] == 1'b1, "R10 busy while request low", v, 32'd4);
    wr(3'd0, ctrlw(1, 0, 0, 0, 0) & ~32'd1);
    rd(3'd4, v);
    check(v[2] == 1'b0, "R8 abort clears busy", v, 32'd0);
    xfer_req = 1'b1;
    repeat (12) @(negedge clk);
    rd(3'd4, v);
    check(v[1:0] == 2'b00, "R8 no done after abort", v, 32'd0);

    // R8 reset bit clears error
    run_bad("pre-reset", 0, 0, 32'h010, 32'h200, 3);
    wr(3'd3, 32'd3);
    wr(3'd0, ctrlw(1, 0, 0, 0, 0));
    rd(3'd4, v);
    check(v[1] == 1'b1, "R7 error set again", v, 32'd2);
    wr(3'd0, 32'd4);
    rd(3'd4, v);
    check(v[1:0] == 2'b00, "R8 reset bit clears status", v, 32'd0);

    // R8 abort mid-transfer via reset bit
    exp_q.delete();
    xfer_req = 1'b0;
    wr(3'd1, 32'h110); wr(3'd2, 32'h3C0); wr(3'd3, 32'd16);
    wr(3'd0, ctrlw(1, 0, 0, 0, 0));
    wr(3'd0, 32'd5);
    xfer_req = 1'b1;
    repeat (12) @(negedge clk);
    rd(3'd4, v);
    check(v[2:0] == 3'b000, "R8 reset bit aborts", v, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule